// File: doc/BRIEF.md
# Capture/Compare/PWM Channel with Event Trigger

This block is one timer-driven peripheral channel built around a 16-bit register that is written and read one byte at a time. A 4-bit mode input picks how the register is used. In capture mode it stores the shared timer-1 count when a chosen edge pattern appears on the capture input. In compare mode it watches timer-1 and acts on the first cycle that the count equals the register. In PWM mode its low byte is the duty value for an output clocked by the timer-2 count and restarted by the timer-2 period-match pulse.

One compare sub-mode is a special event trigger. On a match it pulses a request that clears both bytes of timer-1. When the `ADC_TRIG` parameter is set, the same match also pulses an A/D start request, but only while the ADC-enable input is high. Several channels can share the same timer inputs. They then capture and compare against one time base, and in PWM mode they restart together, so their rising edges line up.

The output pin comes from a two-state machine with the states `PIN_LOW` and `PIN_HIGH`.
- `PIN_LOW` moves to `PIN_HIGH` on a compare match in set-high mode.
- `PIN_LOW` also moves to `PIN_HIGH` on a PWM period match when the new duty is not zero.
- `PIN_HIGH` moves to `PIN_LOW` on a compare match in clear-low mode.
- `PIN_HIGH` also moves to `PIN_LOW` on a PWM period match with zero duty, or when the timer-2 count reaches the buffered duty.
- Any clock edge taken in off mode moves the machine to `PIN_LOW`.

Top module: `ccp_channel`

## Requirements
- R1: A write with `wr_addr_i`=0 loads the low byte of the register, and a write with `wr_addr_i`=1 loads the high byte. `rd_data_o` shows the low byte when `rd_addr_i`=0 and the high byte when `rd_addr_i`=1.
- R2: With mode 4'b0100, a falling edge on `cap_pin_i` copies `t1_count_i` into the register and pulses `irq_o` for one cycle. A rising edge captures nothing.
- R3: With mode 4'b0101, each rising edge on `cap_pin_i` captures `t1_count_i` and pulses `irq_o`.
- R4: With mode 4'b0110, a capture happens on every 4th rising edge. With mode 4'b0111, a capture happens on every 16th rising edge. Rising edges that do not capture leave `irq_o` low.
- R5: With mode 4'b1000, a compare match drives `ccp_pin_o` high and pulses `irq_o`.
- R6: With mode 4'b1001, a compare match drives `ccp_pin_o` low and pulses `irq_o`.
- R7: With mode 4'b1010, a compare match pulses `irq_o` and leaves `ccp_pin_o` unchanged.
- R8: With mode 4'b1011, a compare match pulses `t1_clear_o` and `irq_o` for one cycle and leaves `ccp_pin_o` unchanged.
- R9: `adc_start_o` pulses together with `t1_clear_o` only when `adc_en_i` is high. It never pulses in the other compare modes.
- R10: A compare match fires once, on the first cycle that `t1_count_i` equals the full 16-bit register. Further cycles at the same count do not fire again.
- R11: In PWM mode (mode 4'b11xx) the low byte is buffered and takes effect at the next `t2_match_i`. At that point `ccp_pin_o` goes high, unless the buffered duty is zero. `ccp_pin_o` goes low when `t2_count_i` equals the buffered duty.
- R12: With mode 4'b00xx, `ccp_pin_o` is low in the same cycle, the pin state is cleared at the next edge, and the capture prescaler count is reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 4 | Operating mode select |
| t1_count_i | input | 16 | Shared timer-1 count |
| t2_count_i | input | 8 | Shared timer-2 count |
| t2_match_i | input | 1 | Timer-2 period-match pulse |
| cap_pin_i | input | 1 | Capture input pin |
| adc_en_i | input | 1 | A/D converter enabled |
| wr_en_i | input | 1 | Byte write strobe |
| wr_addr_i | input | 1 | Write byte select (0 low, 1 high) |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 1 | Read byte select (0 low, 1 high) |
| rd_data_o | output | 8 | Read data |
| ccp_pin_o | output | 1 | Compare/PWM output pin |
| irq_o | output | 1 | One-cycle interrupt flag pulse |
| t1_clear_o | output | 1 | Timer-1 clear request pulse |
| adc_start_o | output | 1 | A/D start request pulse |

## Verification
Capture is driven with isolated rising and falling edges, and with trains of 4 and 16 rising edges carrying different timer values. This shows which edge fires and which edge of a train is recorded. It also checks that leaving to off mode part-way through a train clears the prescaler count. Compare is driven with the timer stepping through the match and also holding on it. This separates the set-high, clear-low, flag-only and trigger actions, confirms that a held match fires once, and shows the A/D request gated by its enable. PWM is given a duty written in mid-period and a zero duty. This shows that a new duty waits for the period match and that a zero duty keeps the pin low.

// File: rtl/ccp_pkg.sv
package ccp_pkg;

    typedef enum logic [3:0] {
        MODE_OFF        = 4'b0000,
        MODE_CAP_FALL   = 4'b0100,
        MODE_CAP_RISE   = 4'b0101,
        MODE_CAP_RISE4  = 4'b0110,
        MODE_CAP_RISE16 = 4'b0111,
        MODE_CMP_SET    = 4'b1000,
        MODE_CMP_CLR    = 4'b1001,
        MODE_CMP_FLAG   = 4'b1010,
        MODE_CMP_TRIG   = 4'b1011,
        MODE_PWM        = 4'b1100
    } mode_e;

    typedef enum logic {
        PIN_LOW  = 1'b0,
        PIN_HIGH = 1'b1
    } pin_state_e;

    function automatic logic mode_is_off(input logic [3:0] m);
        return m[3:2] == 2'b00;
    endfunction

    function automatic logic mode_is_capture(input logic [3:0] m);
        return m[3:2] == 2'b01;
    endfunction

    function automatic logic mode_is_compare(input logic [3:0] m);
        return m[3:2] == 2'b10;
    endfunction

    function automatic logic mode_is_pwm(input logic [3:0] m);
        return m[3:2] == 2'b11;
    endfunction

endpackage

// File: rtl/ccp_capture_trig.sv
module ccp_capture_trig
    import ccp_pkg::*;
#(
    parameter int PRESC_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] mode_i,
    input  logic       pin_i,
    output logic       fire_o
);
    localparam logic [PRESC_W-1:0] LAST_OF_4  = PRESC_W'(3);
    localparam logic [PRESC_W-1:0] LAST_OF_16 = PRESC_W'(15);

    logic               pin_q;
    logic [PRESC_W-1:0] cnt_q;
    logic [PRESC_W-1:0] cnt_d;
    logic               rise;
    logic               fall;

    assign rise = pin_i & ~pin_q;
    assign fall = ~pin_i & pin_q;

    always_comb begin
        fire_o = 1'b0;
        cnt_d  = cnt_q;
        case (mode_i)
            MODE_CAP_FALL: fire_o = fall;
            MODE_CAP_RISE: fire_o = rise;
            MODE_CAP_RISE4: begin
                if (rise) begin
                    if (cnt_q == LAST_OF_4) begin
                        fire_o = 1'b1;
                        cnt_d  = '0;
                    end else begin
                        cnt_d = cnt_q + PRESC_W'(1);
                    end
                end
            end
            MODE_CAP_RISE16: begin
                if (rise) begin
                    if (cnt_q == LAST_OF_16) begin
                        fire_o = 1'b1;
                        cnt_d  = '0;
                    end else begin
                        cnt_d = cnt_q + PRESC_W'(1);
                    end
                end
            end
            default: ;
        endcase
        if (mode_is_off(mode_i)) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            pin_q <= pin_i;
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/ccp_compare_hit.sv
module ccp_compare_hit #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active_i,
    input  logic [W-1:0] count_i,
    input  logic [W-1:0] ref_i,
    output logic         hit_o
);
    logic equal;
    logic equal_q;

    assign equal = active_i && (count_i == ref_i);
    assign hit_o = equal & ~equal_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            equal_q <= 1'b0;
        end else begin
            equal_q <= equal;
        end
    end

endmodule

// File: rtl/ccp_pwm_timing.sv
module ccp_pwm_timing #(
    parameter int T2_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            active_i,
    input  logic            period_i,
    input  logic [T2_W-1:0] count_i,
    input  logic [T2_W-1:0] duty_i,
    output logic            load_o,
    output logic            zero_o,
    output logic            reach_o
);
    logic [T2_W-1:0] duty_buf_q;

    assign load_o  = active_i & period_i;
    assign zero_o  = (duty_i == '0);
    assign reach_o = active_i && (count_i == duty_buf_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_buf_q <= '0;
        end else if (load_o) begin
            duty_buf_q <= duty_i;
        end
    end

endmodule

// File: rtl/ccp_channel.sv
module ccp_channel
    import ccp_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int T2_W     = 8,
    parameter int PRESC_W  = 4,
    parameter bit ADC_TRIG = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [3:0]          mode_i,
    input  logic [2*DATA_W-1:0] t1_count_i,
    input  logic [T2_W-1:0]     t2_count_i,
    input  logic                t2_match_i,
    input  logic                cap_pin_i,
    input  logic                adc_en_i,
    input  logic                wr_en_i,
    input  logic                wr_addr_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    input  logic                rd_addr_i,
    output logic [DATA_W-1:0]   rd_data_o,
    output logic                ccp_pin_o,
    output logic                irq_o,
    output logic                t1_clear_o,
    output logic                adc_start_o
);
    localparam int REG_W = 2 * DATA_W;

    logic [REG_W-1:0] ccpr;
    logic             cap_fire;
    logic             cmp_hit;
    logic             pwm_load;
    logic             pwm_zero;
    logic             pwm_reach;
    logic             trig_hit;
    logic             adc_fire;
    pin_state_e       pin_state;
    pin_state_e       pin_next;

    ccp_capture_trig #(.PRESC_W(PRESC_W)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (mode_i),
        .pin_i  (cap_pin_i),
        .fire_o (cap_fire)
    );

    ccp_compare_hit #(.W(REG_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (mode_is_compare(mode_i)),
        .count_i  (t1_count_i),
        .ref_i    (ccpr),
        .hit_o    (cmp_hit)
    );

    ccp_pwm_timing #(.T2_W(T2_W)) u_pwm (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (mode_is_pwm(mode_i)),
        .period_i (t2_match_i),
        .count_i  (t2_count_i),
        .duty_i   (ccpr[T2_W-1:0]),
        .load_o   (pwm_load),
        .zero_o   (pwm_zero),
        .reach_o  (pwm_reach)
    );

    assign trig_hit = cmp_hit && (mode_i == MODE_CMP_TRIG);

    generate
        if (ADC_TRIG) begin : g_adc
            assign adc_fire = trig_hit & adc_en_i;
        end else begin : g_no_adc
            assign adc_fire = 1'b0;
        end
    endgenerate

    // Register: a hardware capture wins over a software byte write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ccpr <= '0;
        end else if (cap_fire) begin
            ccpr <= t1_count_i;
        end else if (wr_en_i) begin
            if (wr_addr_i) begin
                ccpr[REG_W-1:DATA_W] <= wr_data_i;
            end else begin
                ccpr[DATA_W-1:0] <= wr_data_i;
            end
        end
    end

    assign rd_data_o = rd_addr_i ? ccpr[REG_W-1:DATA_W] : ccpr[DATA_W-1:0];

    // Pin state machine: next-state logic
    always_comb begin
        pin_next = pin_state;
        unique case (pin_state)
            PIN_LOW: begin
                if (mode_is_off(mode_i)) begin
                    pin_next = PIN_LOW;
                end else if (cmp_hit && (mode_i == MODE_CMP_SET)) begin
                    pin_next = PIN_HIGH;
                end else if (pwm_load && !pwm_zero) begin
                    pin_next = PIN_HIGH;
                end
            end
            PIN_HIGH: begin
                if (mode_is_off(mode_i)) begin
                    pin_next = PIN_LOW;
                end else if (cmp_hit && (mode_i == MODE_CMP_CLR)) begin
                    pin_next = PIN_LOW;
                end else if (pwm_load) begin
                    pin_next = pwm_zero ? PIN_LOW : PIN_HIGH;
                end else if (pwm_reach) begin
                    pin_next = PIN_LOW;
                end
            end
            default: pin_next = PIN_LOW;
        endcase
    end

    // Pin state machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_state <= PIN_LOW;
        end else begin
            pin_state <= pin_next;
        end
    end

    // Event outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o       <= 1'b0;
            t1_clear_o  <= 1'b0;
            adc_start_o <= 1'b0;
        end else begin
            irq_o       <= cap_fire | cmp_hit;
            t1_clear_o  <= trig_hit;
            adc_start_o <= adc_fire;
        end
    end

    assign ccp_pin_o = (pin_state == PIN_HIGH) && !mode_is_off(mode_i);

endmodule

// File: rtl/ccp_channel_sva.sv
module ccp_channel_sva
    import ccp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [3:0]          mode_i,
    input logic [2*DATA_W-1:0] t1_count_i,
    input logic                t2_match_i,
    input logic                adc_en_i,
    input logic [2*DATA_W-1:0] ccpr,
    input logic                ccp_pin_o,
    input logic                irq_o,
    input logic                t1_clear_o,
    input logic                adc_start_o
);

    assert_irq_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (mode_is_capture($past(mode_i)) || mode_is_compare($past(mode_i))));

    assert_capture_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && mode_is_capture($past(mode_i))) |-> (ccpr == $past(t1_count_i)));

    assert_trig_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        t1_clear_o |-> (irq_o && ($past(mode_i) == MODE_CMP_TRIG)));

    assert_adc_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start_o |-> (t1_clear_o && $past(adc_en_i)));

    assert_zero_duty_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_is_pwm(mode_i) && t2_match_i && (ccpr[DATA_W-1:0] == '0)) |=> !ccp_pin_o);

endmodule

bind ccp_channel ccp_channel_sva #(.DATA_W(DATA_W)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .t1_count_i  (t1_count_i),
    .t2_match_i  (t2_match_i),
    .adc_en_i    (adc_en_i),
    .ccpr        (ccpr),
    .ccp_pin_o   (ccp_pin_o),
    .irq_o       (irq_o),
    .t1_clear_o  (t1_clear_o),
    .adc_start_o (adc_start_o)
);

// File: tb/ccp_channel_tb.sv
module ccp_channel_tb;
    import ccp_pkg::*;

    logic        clk;
    logic        rst_n;
    logic [3:0]  mode;
    logic [15:0] t1;
    logic [7:0]  t2;
    logic        t2m;
    logic        cap;
    logic        adc_en;
    logic        wr_en;
    logic        wr_addr;
    logic [7:0]  wr_data;
    logic        rd_addr;
    logic [7:0]  rd_data;
    logic        pin;
    logic        irq;
    logic        t1clr;
    logic        adc;

    int tests = 0;
    int fails = 0;

    ccp_channel u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode),
        .t1_count_i  (t1),
        .t2_count_i  (t2),
        .t2_match_i  (t2m),
        .cap_pin_i   (cap),
        .adc_en_i    (adc_en),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .rd_addr_i   (rd_addr),
        .rd_data_o   (rd_data),
        .ccp_pin_o   (pin),
        .irq_o       (irq),
        .t1_clear_o  (t1clr),
        .adc_start_o (adc)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_byte(input logic a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd_word(output logic [15:0] v);
        rd_addr = 1'b0; #1; v[7:0] = rd_data;
        rd_addr = 1'b1; #1; v[15:8] = rd_data;
    endtask

    task automatic test_reset();
        logic [15:0] v;
        rd_word(v);
        chk("reset R1 reg", v, 16'h0000);
        chk("reset R12 pin", {15'd0, pin}, 16'd0);
        chk("reset R2 irq", {15'd0, irq}, 16'd0);
    endtask

    task automatic test_bytes_R1();
        logic [15:0] v;
        wr_byte(1'b0, 8'h34);
        wr_byte(1'b1, 8'h12);
        rd_word(v);
        chk("R1 byte write/read", v, 16'h1234);
    endtask

    task automatic test_cap_fall_R2();
        logic [15:0] v;
        mode = MODE_CAP_FALL; cap = 1'b1; t1 = 16'h0BAD;
        step();
        chk("R2 rising ignored irq", {15'd0, irq}, 16'd0);
        rd_word(v);
        chk("R2 rising ignored reg", v, 16'h1234);
        t1 = 16'hA5C3; cap = 1'b0;
        step();
        chk("R2 falling irq", {15'd0, irq}, 16'd1);
        rd_word(v);
        chk("R2 falling value", v, 16'hA5C3);
        step();
        chk("R2 irq one cycle", {15'd0, irq}, 16'd0);
    endtask

    task automatic test_cap_rise_R3();
        logic [15:0] v;
        mode = MODE_CAP_RISE; t1 = 16'h2222; cap = 1'b1;
        step();
        chk("R3 rising irq", {15'd0, irq}, 16'd1);
        rd_word(v);
        chk("R3 rising value", v, 16'h2222);
        cap = 1'b0; t1 = 16'h3333;
        step();
        chk("R3 falling ignored", {15'd0, irq}, 16'd0);
    endtask

    task automatic rise_train(input int n, input logic [15:0] base, input string req);
        for (int i = 0; i < n; i++) begin
            t1 = base + 16'(i); cap = 1'b1;
            step();
            chk(req, {15'd0, irq}, {15'd0, (i == n - 1)});
            cap = 1'b0;
            step();
        end
    endtask

    task automatic test_prescale_R4();
        logic [15:0] v;
        mode = MODE_OFF; cap = 1'b0; step();
        mode = MODE_CAP_RISE4;
        rise_train(4, 16'h4000, "R4 div4 irq");
        rd_word(v);
        chk("R4 div4 value", v, 16'h4003);
        mode = MODE_OFF; step();
        mode = MODE_CAP_RISE16;
        rise_train(16, 16'h5000, "R4 div16 irq");
        rd_word(v);
        chk("R4 div16 value", v, 16'h500F);
    endtask

    task automatic test_prescale_reset_R12();
        logic [15:0] v;
        mode = MODE_OFF; step();
        mode = MODE_CAP_RISE4;
        for (int i = 0; i < 2; i++) begin
            t1 = 16'h6000; cap = 1'b1; step(); cap = 1'b0; step();
        end
        mode = MODE_OFF; step();
        mode = MODE_CAP_RISE4;
        for (int i = 0; i < 2; i++) begin
            t1 = 16'h6100 + 16'(i); cap = 1'b1; step();
            chk("R12 prescaler cleared", {15'd0, irq}, 16'd0);
            cap = 1'b0; step();
        end
        rise_train(2, 16'h6200, "R12 count restarts");
        rd_word(v);
        chk("R12 capture after restart", v, 16'h6201);
    endtask

    task automatic test_cmp_set_R5();
        mode = MODE_OFF; step();
        wr_byte(1'b0, 8'h00);
        wr_byte(1'b1, 8'h01);
        t1 = 16'h00FF; mode = MODE_CMP_SET;
        step();
        chk("R5 no match pin", {15'd0, pin}, 16'd0);
        t1 = 16'h0100;
        step();
        chk("R5 match pin high", {15'd0, pin}, 16'd1);
        chk("R5 match irq", {15'd0, irq}, 16'd1);
        t1 = 16'h0101;
        step();
        chk("R5 pin holds", {15'd0, pin}, 16'd1);
        chk("R5 irq drops", {15'd0, irq}, 16'd0);
    endtask

    task automatic test_cmp_clr_R6();
        wr_byte(1'b1, 8'h02);
        mode = MODE_CMP_CLR; t1 = 16'h0200;
        step();
        chk("R6 match pin low", {15'd0, pin}, 16'd0);
        chk("R6 match irq", {15'd0, irq}, 16'd1);
    endtask

    task automatic test_cmp_flag_R7_R10();
        mode = MODE_CMP_SET; t1 = 16'h01FF; step();
        t1 = 16'h0200; step();
        chk("R7 setup pin high", {15'd0, pin}, 16'd1);
        mode = MODE_CMP_FLAG; t1 = 16'h0201; step();
        t1 = 16'h0200;
        step();
        chk("R7 flag irq", {15'd0, irq}, 16'd1);
        chk("R7 pin unchanged", {15'd0, pin}, 16'd1);
        chk("R7 no clear", {15'd0, t1clr}, 16'd0);
        step();
        chk("R10 held match no refire", {15'd0, irq}, 16'd0);
        step();
        chk("R10 held match still quiet", {15'd0, irq}, 16'd0);
    endtask

    task automatic test_trig_R8_R9();
        wr_byte(1'b1, 8'h03);
        wr_byte(1'b0, 8'h00);
        mode = MODE_CMP_TRIG; adc_en = 1'b0; t1 = 16'h02FF; step();
        t1 = 16'h0300;
        step();
        chk("R8 clear pulse", {15'd0, t1clr}, 16'd1);
        chk("R8 irq", {15'd0, irq}, 16'd1);
        chk("R8 pin unchanged", {15'd0, pin}, 16'd1);
        chk("R9 adc gated off", {15'd0, adc}, 16'd0);
        t1 = 16'h0301;
        step();
        chk("R8 clear one cycle", {15'd0, t1clr}, 16'd0);
        adc_en = 1'b1; t1 = 16'h02FF; step();
        t1 = 16'h0300;
        step();
        chk("R9 adc start", {15'd0, adc}, 16'd1);
        chk("R9 with clear", {15'd0, t1clr}, 16'd1);
        mode = MODE_CMP_FLAG; t1 = 16'h02FF; step();
        t1 = 16'h0300;
        step();
        chk("R9 flag mode irq", {15'd0, irq}, 16'd1);
        chk("R9 flag mode no adc", {15'd0, adc}, 16'd0);
        chk("R9 flag mode no clear", {15'd0, t1clr}, 16'd0);
        adc_en = 1'b0;
    endtask

    task automatic test_off_R12();
        chk("R12 pin high before off", {15'd0, pin}, 16'd1);
        mode = MODE_OFF; #1;
        chk("R12 immediate low", {15'd0, pin}, 16'd0);
        step();
        mode = MODE_CMP_FLAG; t1 = 16'h0000;
        step();
        chk("R12 state cleared", {15'd0, pin}, 16'd0);
    endtask

    task automatic test_pwm_R11();
        mode = MODE_OFF; step();
        wr_byte(1'b0, 8'h05);
        mode = MODE_PWM; t2 = 8'd3; t2m = 1'b0;
        step();
        chk("R11 before period match", {15'd0, pin}, 16'd0);
        t2 = 8'd9; t2m = 1'b1;
        step();
        chk("R11 period match high", {15'd0, pin}, 16'd1);
        t2m = 1'b0; t2 = 8'd0;
        wr_byte(1'b0, 8'h02);
        chk("R11 write mid-period", {15'd0, pin}, 16'd1);
        for (int c = 1; c <= 4; c++) begin
            t2 = 8'(c); step();
            chk("R11 buffered duty high", {15'd0, pin}, 16'd1);
        end
        t2 = 8'd5; step();
        chk("R11 duty reached low", {15'd0, pin}, 16'd0);
        t2 = 8'd6; step();
        chk("R11 stays low", {15'd0, pin}, 16'd0);
        t2 = 8'd9; t2m = 1'b1; step();
        chk("R11 second period high", {15'd0, pin}, 16'd1);
        t2m = 1'b0;
        t2 = 8'd0; step();
        t2 = 8'd1; step();
        chk("R11 new duty high", {15'd0, pin}, 16'd1);
        t2 = 8'd2; step();
        chk("R11 new duty low", {15'd0, pin}, 16'd0);
        wr_byte(1'b0, 8'h00);
        t2 = 8'd9; t2m = 1'b1; step();
        chk("R11 zero duty low", {15'd0, pin}, 16'd0);
        t2m = 1'b0;
        for (int c = 0; c < 4; c++) begin
            t2 = 8'(c); step();
            chk("R11 zero duty stays low", {15'd0, pin}, 16'd0);
        end
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mode = MODE_OFF; t1 = '0; t2 = '0; t2m = 1'b0; cap = 1'b0;
        adc_en = 1'b0; wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0; rd_addr = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
        test_reset();
        test_bytes_R1();
        test_cap_fall_R2();
        test_cap_rise_R3();
        test_prescale_R4();
        test_prescale_reset_R12();
        test_cmp_set_R5();
        test_cmp_clr_R6();
        test_cmp_flag_R7_R10();
        test_trig_R8_R9();
        test_off_R12();
        test_pwm_R11();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule